// File: doc/BRIEF.md
# Exception entry and return controller

This block sits in the control path of a small processor and handles taking and leaving exceptions. It holds the current status word, which carries the condition flags, the two interrupt mask bits and the five-bit mode field. It also holds one saved-status register and one link register for each of the five exception modes. When an exception request is accepted, the block saves the status into the handler mode's saved-status register, switches the mode, sets the masks, stores the return address in the handler mode's link register and redirects the program counter to that exception's vector. All of this happens on a single clock edge.

A return strobe loads the program counter from a supplied return value and, on the same edge, restores the status word from the current mode's saved-status register. Two return strobes exist, one for a flag-setting data-processing return and one for a block-load return, and they behave the same way. The rest of the core reads back the current mode's banked link register and saved status. It can also write the status word directly, but in user mode only the flags can be written that way.

Top module: `exc_ctrl`

## Requirements
- R1: Status word layout is bits [10:7] flags, [6] IRQ mask, [5] FIQ mask, [4:0] mode; modes are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. After reset the status is flags 0, both masks set, supervisor mode. After reset `pc_nxt_o` is 0 and `redir_o` and `err_o` are 0.
- R2: On an accepted non-reset exception, the whole status word is copied into the saved-status register of the handler mode and the mode field becomes that handler mode (undefined→undefined, software interrupt→supervisor, either abort→abort, IRQ→IRQ, FIQ→FIQ). Both changes are visible on `psr_o` and `spsr_o` one cycle later.
- R3: Every accepted exception sets the IRQ mask. The FIQ mask is set only by FIQ or reset entry; every other exception leaves it unchanged.
- R4: On entry, the handler mode's link register receives `pc_i` plus 8 for a data abort and plus 4 for every other non-reset exception. It is readable on `lr_o` while that mode is current.
- R5: One cycle after acceptance, `pc_nxt_o` equals `VEC_BASE` plus the vector offset and `redir_o` pulses for one cycle. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R6: Request bits of `req_i` are [0] reset, [1] data abort, [2] FIQ, [3] IRQ, [4] prefetch abort, [5] undefined, [6] software interrupt. When several are eligible, the lowest index is accepted.
- R7: An FIQ request is ignored while the FIQ mask is set, and an IRQ request is ignored while the IRQ mask is set. A lower-priority eligible request is accepted instead.
- R8: A return strobe (`ret_dp_i` or `ret_ldm_i`) in a mode that has a saved-status register loads `pc_nxt_o` from `ret_val_i` and restores `psr_o` from the saved status on the same edge, with a `redir_o` pulse.
- R9: A return strobe in user or system mode leaves the status and `pc_nxt_o` unchanged, gives no redirect, and pulses `err_o` for one cycle.
- R10: A reset request enters supervisor mode with both masks set and the flags kept, and jumps to offset 0x00. It writes no link or saved-status register.
- R11: A status write replaces the whole word in a privileged mode and only the flags in user mode. An accepted exception takes precedence over a return strobe, and a return strobe takes precedence over a status write.
- R12: Each mode's link and saved-status registers are separate: entering one mode leaves the other modes' registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 7 | Exception request bits, one per exception |
| pc_i | input | AW | PC of the instruction in progress, used for the return address |
| ret_dp_i | input | 1 | Data-processing return strobe |
| ret_ldm_i | input | 1 | Block-load return strobe |
| ret_val_i | input | AW | Return target for the PC |
| psr_we_i | input | 1 | Status write enable |
| psr_wd_i | input | 11 | Status write data |
| pc_nxt_o | output | AW | Redirect target |
| redir_o | output | 1 | One-cycle pulse: `pc_nxt_o` holds a new target |
| psr_o | output | 11 | Current status word |
| lr_o | output | AW | Link register of the current mode, 0 in user or system mode |
| spsr_o | output | 11 | Saved status of the current mode, 0 in user or system mode |
| err_o | output | 1 | One-cycle pulse: return requested without a saved status |

## Verification
The hardest state to reach is a return strobe in user mode. Reset leaves the block in supervisor mode, so the core can only get to user mode through a privileged status write or through a return whose saved status holds user mode. The bench first steers there with directed status writes. Its random phase then writes legal modes often enough to keep revisiting user and system mode. That random phase also mixes FIQ and IRQ requests with random mask states, so masked and unmasked collisions between the two occur many times.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int PSR_W  = 11;
  localparam int NREQ   = 7;
  localparam int IDX_W  = $clog2(NREQ);
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);

  typedef logic [IDX_W-1:0] xidx_t;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  // request index order doubles as priority order (lowest wins)
  localparam xidx_t X_RST  = 3'd0;
  localparam xidx_t X_DABT = 3'd1;
  localparam xidx_t X_FIQ  = 3'd2;
  localparam xidx_t X_IRQ  = 3'd3;
  localparam xidx_t X_PABT = 3'd4;
  localparam xidx_t X_UND  = 3'd5;
  localparam xidx_t X_SWI  = 3'd6;

  typedef struct packed {
    logic [3:0] flags;
    logic       irq_m;
    logic       fiq_m;
    logic [4:0] mode;
  } psr_t;

  localparam psr_t PSR_RST = '{flags: 4'h0, irq_m: 1'b1, fiq_m: 1'b1, mode: M_SVC};

  typedef struct packed {
    logic              vld;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t bank_of(input logic [4:0] m);
    bank_sel_t s;
    s.vld = 1'b1;
    case (m)
      M_FIQ:   s.idx = BANK_W'(0);
      M_IRQ:   s.idx = BANK_W'(1);
      M_SVC:   s.idx = BANK_W'(2);
      M_ABT:   s.idx = BANK_W'(3);
      M_UND:   s.idx = BANK_W'(4);
      default: begin s.vld = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  function automatic logic [4:0] handler_mode(input xidx_t x);
    case (x)
      X_DABT, X_PABT: return M_ABT;
      X_FIQ:          return M_FIQ;
      X_IRQ:          return M_IRQ;
      X_UND:          return M_UND;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_off(input xidx_t x);
    case (x)
      X_DABT:  return 8'h10;
      X_FIQ:   return 8'h1C;
      X_IRQ:   return 8'h18;
      X_PABT:  return 8'h0C;
      X_UND:   return 8'h04;
      X_SWI:   return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] lr_adj(input xidx_t x);
    case (x)
      X_RST:   return 4'd0;
      X_DABT:  return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic masks_fiq(input xidx_t x);
    return (x == X_RST) || (x == X_FIQ);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N  = NREQ,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic          irq_m,
  input  logic          fiq_m,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);

  logic [N-1:0] elig;

  for (genvar i = 0; i < N; i++) begin : g_elig
    if (i == int'(X_FIQ)) begin : g_fiq
      assign elig[i] = req[i] & ~fiq_m;
    end else if (i == int'(X_IRQ)) begin : g_irq
      assign elig[i] = req[i] & ~irq_m;
    end else begin : g_plain
      assign elig[i] = req[i];
    end
  end

  always_comb begin
    gnt_vld = |elig;
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) gnt_idx = IW'(i);
    end
  end

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int NB = NBANK,
  localparam int SW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [AW-1:0] lr_d,
  input  psr_t          spsr_d,
  input  logic          rvld,
  input  logic [SW-1:0] rsel,
  output logic [AW-1:0] lr_q,
  output psr_t          spsr_q
);

  logic [NB-1:0][AW-1:0]    lr_all;
  logic [NB-1:0][PSR_W-1:0] sp_all;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          en;
    logic [AW-1:0] lr_r;
    psr_t          sp_r;

    assign en = we && (wsel == SW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lr_r <= '0;
        sp_r <= '0;
      end else if (en) begin
        lr_r <= lr_d;
        sp_r <= spsr_d;
      end
    end

    assign lr_all[b] = lr_r;
    assign sp_all[b] = sp_r;
  end

  always_comb begin
    lr_q   = '0;
    spsr_q = '0;
    for (int b = 0; b < NB; b++) begin
      if (rvld && (rsel == SW'(b))) begin
        lr_q   = lr_all[b];
        spsr_q = sp_all[b];
      end
    end
  end

endmodule

// File: rtl/exc_psr_unit.sv
module exc_psr_unit
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [4:0] take_mode,
  input  logic       take_mfiq,
  input  logic       ret_ok,
  input  psr_t       ret_psr,
  input  logic       wr_en,
  input  psr_t       wr_psr,
  output psr_t       psr_q
);

  psr_t psr_d;
  logic psr_en;

  always_comb begin
    psr_d  = psr_q;
    psr_en = take | ret_ok | wr_en;
    if (take) begin
      psr_d.mode  = take_mode;
      psr_d.irq_m = 1'b1;
      if (take_mfiq) psr_d.fiq_m = 1'b1;
    end else if (ret_ok) begin
      psr_d = ret_psr;
    end else if (wr_en) begin
      if (psr_q.mode == M_USR) psr_d.flags = wr_psr.flags;
      else                     psr_d       = wr_psr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psr_q <= PSR_RST;
    else if (psr_en) psr_q <= psr_d;
  end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             ret_dp_i,
  input  logic             ret_ldm_i,
  input  logic [AW-1:0]    ret_val_i,
  input  logic             psr_we_i,
  input  logic [PSR_W-1:0] psr_wd_i,
  output logic [AW-1:0]    pc_nxt_o,
  output logic             redir_o,
  output logic [PSR_W-1:0] psr_o,
  output logic [AW-1:0]    lr_o,
  output logic [PSR_W-1:0] spsr_o,
  output logic             err_o
);

  // reset: asserted asynchronously, released on the second edge
  logic [1:0] rst_sh;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_sync_n = rst_sh[1];

  psr_t      psr_q;
  psr_t      spsr_cur;
  bank_sel_t cur_b;
  bank_sel_t new_b;
  logic      take;
  xidx_t     gidx;
  logic [4:0] new_mode;
  logic      bank_we;
  logic [AW-1:0] lr_d;
  logic      ret_req, ret_ok, ret_bad, wr_en;
  logic      pc_en;
  logic [AW-1:0] pc_d;
  logic [AW-1:0] pc_q;
  logic      redir_q, err_q;

  exc_arbiter #(.N(NREQ)) u_arb (
    .req     (req_i),
    .irq_m   (psr_q.irq_m),
    .fiq_m   (psr_q.fiq_m),
    .gnt_vld (take),
    .gnt_idx (gidx)
  );

  always_comb begin
    cur_b    = bank_of(psr_q.mode);
    new_mode = handler_mode(gidx);
    new_b    = bank_of(new_mode);
    bank_we  = take && (gidx != X_RST) && new_b.vld;
    lr_d     = pc_i + AW'(lr_adj(gidx));
    ret_req  = ret_dp_i | ret_ldm_i;
    ret_ok   = !take && ret_req && cur_b.vld;
    ret_bad  = !take && ret_req && !cur_b.vld;
    wr_en    = psr_we_i && !take && !ret_req;
    pc_en    = take | ret_ok;
    pc_d     = take ? (VEC_BASE + AW'(vec_off(gidx))) : ret_val_i;
  end

  exc_bank_file #(.AW(AW), .NB(NBANK)) u_banks (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (bank_we),
    .wsel   (new_b.idx),
    .lr_d   (lr_d),
    .spsr_d (psr_q),
    .rvld   (cur_b.vld),
    .rsel   (cur_b.idx),
    .lr_q   (lr_o),
    .spsr_q (spsr_cur)
  );

  exc_psr_unit u_psr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (take),
    .take_mode (new_mode),
    .take_mfiq (masks_fiq(gidx)),
    .ret_ok    (ret_ok),
    .ret_psr   (spsr_cur),
    .wr_en     (wr_en),
    .wr_psr    (psr_t'(psr_wd_i)),
    .psr_q     (psr_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      redir_q <= pc_en;
      err_q   <= ret_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc_nxt_o = pc_q;
  assign redir_o  = redir_q;
  assign err_o    = err_q;
  assign psr_o    = psr_q;
  assign spsr_o   = spsr_cur;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_i,
  input logic             ret_dp_i,
  input logic             ret_ldm_i,
  input logic [AW-1:0]    ret_val_i,
  input logic [AW-1:0]    pc_nxt_o,
  input logic             redir_o,
  input logic [PSR_W-1:0] psr_o,
  input logic [PSR_W-1:0] spsr_o,
  input logic             err_o
);

  psr_t      p;
  bank_sel_t cb;
  logic      acc, ret, priv;

  assign p    = psr_t'(psr_o);
  assign cb   = bank_of(p.mode);
  assign priv = cb.vld;
  assign ret  = ret_dp_i | ret_ldm_i;
  assign acc  = req_i[X_RST] | req_i[X_DABT] | req_i[X_PABT] | req_i[X_UND] | req_i[X_SWI]
              | (req_i[X_FIQ] & ~p.fiq_m) | (req_i[X_IRQ] & ~p.irq_m);

  p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> p.irq_m);

  p_fiq_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_i[X_RST] && !(req_i[X_FIQ] && !p.fiq_m)) |=> (p.fiq_m == $past(p.fiq_m)));

  p_redir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (redir_o && !err_o));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !ret) |=> (!redir_o && !err_o));

  p_dabt_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[X_DABT] && !req_i[X_RST]) |=> (pc_nxt_o == VEC_BASE + AW'(8'h10) && p.mode == M_ABT));

  p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && ret && priv) |=> (redir_o && psr_o == $past(spsr_o) && pc_nxt_o == $past(ret_val_i)));

  p_ret_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && ret && !priv) |=> (err_o && !redir_o && $stable(psr_o)));

  p_rst_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[X_RST] |=> (pc_nxt_o == VEC_BASE && p.mode == M_SVC && p.irq_m && p.fiq_m));

endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_i     (req_i),
  .ret_dp_i  (ret_dp_i),
  .ret_ldm_i (ret_ldm_i),
  .ret_val_i (ret_val_i),
  .pc_nxt_o  (pc_nxt_o),
  .redir_o   (redir_o),
  .psr_o     (psr_o),
  .spsr_o    (spsr_o),
  .err_o     (err_o)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;

  localparam int CLK_P = 10;

  localparam logic [4:0] MU = 5'b10000, MF = 5'b10001, MI = 5'b10010, MS = 5'b10011,
                         MA = 5'b10111, MD = 5'b11011, MY = 5'b11111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req_i = '0;
  logic [31:0] pc_i = '0;
  logic        ret_dp_i = 1'b0, ret_ldm_i = 1'b0;
  logic [31:0] ret_val_i = '0;
  logic        psr_we_i = 1'b0;
  logic [10:0] psr_wd_i = '0;
  logic [31:0] pc_nxt_o, lr_o;
  logic        redir_o, err_o;
  logic [10:0] psr_o, spsr_o;

  int total = 0;
  int bad   = 0;

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pc_i(pc_i),
    .ret_dp_i(ret_dp_i), .ret_ldm_i(ret_ldm_i), .ret_val_i(ret_val_i),
    .psr_we_i(psr_we_i), .psr_wd_i(psr_wd_i),
    .pc_nxt_o(pc_nxt_o), .redir_o(redir_o), .psr_o(psr_o),
    .lr_o(lr_o), .spsr_o(spsr_o), .err_o(err_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference state
  logic [10:0] m_psr;
  logic [31:0] m_pc;
  logic        m_redir, m_err;
  logic [31:0] m_lr [5];
  logic [10:0] m_spsr [5];

  function automatic int f_bank(input logic [4:0] m);
    case (m)
      MF: return 0;  MI: return 1;  MS: return 2;  MA: return 3;  MD: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [4:0] f_hmode(input int x);
    case (x)
      1, 4: return MA;  2: return MF;  3: return MI;  5: return MD;
      default: return MS;
    endcase
  endfunction

  function automatic logic [31:0] f_vec(input int x);
    case (x)
      1: return 32'h10; 2: return 32'h1C; 3: return 32'h18; 4: return 32'h0C;
      5: return 32'h04; 6: return 32'h08; default: return 32'h00;
    endcase
  endfunction

  function automatic logic [31:0] f_adj(input int x);
    return (x == 1) ? 32'd8 : 32'd4;
  endfunction

  function automatic logic [10:0] mk(input logic [3:0] fl, input logic im, input logic fm,
                                     input logic [4:0] md);
    return {fl, im, fm, md};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic model(input logic [6:0] rq, input logic rt, input logic [31:0] rv,
                       input logic [31:0] pc, input logic we, input logic [10:0] wd);
    logic [6:0] el;
    int g, b;
    el = rq;
    if (m_psr[5]) el[2] = 1'b0;
    if (m_psr[6]) el[3] = 1'b0;
    g = -1;
    for (int i = 6; i >= 0; i--) if (el[i]) g = i;
    m_redir = 1'b0;
    m_err   = 1'b0;
    if (g >= 0) begin
      logic [4:0] nm;
      nm = f_hmode(g);
      if (g != 0) begin
        b = f_bank(nm);
        m_spsr[b] = m_psr;
        m_lr[b]   = pc + f_adj(g);
      end
      m_psr[4:0] = nm;
      m_psr[6]   = 1'b1;
      if (g == 0 || g == 2) m_psr[5] = 1'b1;
      m_pc    = f_vec(g);
      m_redir = 1'b1;
    end else if (rt) begin
      b = f_bank(m_psr[4:0]);
      if (b >= 0) begin
        m_psr   = m_spsr[b];
        m_pc    = rv;
        m_redir = 1'b1;
      end else begin
        m_err = 1'b1;
      end
    end else if (we) begin
      if (m_psr[4:0] == MU) m_psr[10:7] = wd[10:7];
      else                  m_psr       = wd;
    end
  endtask

  task automatic compare_all();
    int b;
    logic [31:0] elr;
    logic [10:0] esp;
    b = f_bank(m_psr[4:0]);
    elr = (b >= 0) ? m_lr[b] : 32'h0;
    esp = (b >= 0) ? m_spsr[b] : 11'h0;
    chk(psr_o == m_psr, "R2 R3 R10 R11 psr_o", 32'(psr_o), 32'(m_psr));
    chk(pc_nxt_o == m_pc, "R5 R6 R7 R8 pc_nxt_o", pc_nxt_o, m_pc);
    chk(redir_o == m_redir, "R5 redir_o", 32'(redir_o), 32'(m_redir));
    chk(err_o == m_err, "R9 err_o", 32'(err_o), 32'(m_err));
    chk(lr_o == elr, "R4 R12 lr_o", lr_o, elr);
    chk(spsr_o == esp, "R2 R12 spsr_o", 32'(spsr_o), 32'(esp));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [6:0] rq, input logic rd, input logic rl,
                      input logic [31:0] rv, input logic [31:0] pc,
                      input logic we, input logic [10:0] wd);
    req_i = rq; ret_dp_i = rd; ret_ldm_i = rl; ret_val_i = rv;
    pc_i = pc; psr_we_i = we; psr_wd_i = wd;
    model(rq, rd | rl, rv, pc, we, wd);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 11'h0);
  endtask

  task automatic wr(input logic [10:0] wd);
    step(7'h0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, wd);
  endtask

  task automatic exc(input logic [6:0] rq, input logic [31:0] pc);
    step(rq, 1'b0, 1'b0, 32'h0, pc, 1'b0, 11'h0);
  endtask

  task automatic rtn(input logic ldm, input logic [31:0] rv);
    step(7'h0, ~ldm, ldm, rv, 32'h0, 1'b0, 11'h0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7];
    void'($urandom(32'h5EED_0C1A));
    modes = '{MU, MF, MI, MS, MA, MD, MY};
    m_psr = mk(4'h0, 1'b1, 1'b1, MS);
    m_pc = '0; m_redir = 1'b0; m_err = 1'b0;
    for (int i = 0; i < 5; i++) begin m_lr[i] = '0; m_spsr[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(psr_o == 11'b0000_1_1_10011, "R1 reset psr", 32'(psr_o), 32'h0073);
    chk(pc_nxt_o == 32'h0 && !redir_o && !err_o, "R1 reset pc/pulses",
        {pc_nxt_o[29:0], redir_o, err_o}, 32'h0);
    compare_all();

    // R11 privileged full write, masks cleared
    wr(mk(4'hA, 1'b0, 1'b0, MS));
    chk(psr_o == mk(4'hA, 1'b0, 1'b0, MS), "R11 priv write", 32'(psr_o),
        32'(mk(4'hA, 1'b0, 1'b0, MS)));

    // R2 R4 R5 undefined entry
    exc(7'b010_0000, 32'h100);
    chk(lr_o == 32'h104, "R4 undefined lr", lr_o, 32'h104);
    chk(spsr_o == mk(4'hA, 1'b0, 1'b0, MS), "R2 saved status", 32'(spsr_o),
        32'(mk(4'hA, 1'b0, 1'b0, MS)));
    chk(pc_nxt_o == 32'h04 && redir_o, "R5 undefined vector", pc_nxt_o, 32'h04);
    idle();
    // R8 return restores status
    rtn(1'b0, 32'h100);
    chk(psr_o == mk(4'hA, 1'b0, 1'b0, MS) && pc_nxt_o == 32'h100, "R8 dp return",
        32'(psr_o), 32'(mk(4'hA, 1'b0, 1'b0, MS)));

    // R6 priority: all except reset -> data abort
    exc(7'b111_1110, 32'h200);
    chk(pc_nxt_o == 32'h10 && psr_o[4:0] == MA, "R6 dabt wins", pc_nxt_o, 32'h10);
    chk(lr_o == 32'h208, "R4 dabt offset", lr_o, 32'h208);
    rtn(1'b1, 32'h1F8);

    // R3 FIQ beats IRQ, sets both masks
    exc(7'b000_1100, 32'h300);
    chk(psr_o[6:5] == 2'b11 && psr_o[4:0] == MF, "R3 fiq masks", 32'(psr_o), 32'(mk(4'hA,1,1,MF)));
    // R7 both masked -> prefetch abort taken
    exc(7'b001_1100, 32'h400);
    chk(pc_nxt_o == 32'h0C, "R7 masked irq/fiq skipped", pc_nxt_o, 32'h0C);
    rtn(1'b0, 32'h400);
    rtn(1'b1, 32'h300);

    // R7 only FIQ masked -> IRQ; R3 FIQ mask kept
    wr(mk(4'h3, 1'b0, 1'b1, MS));
    exc(7'b000_1100, 32'h500);
    chk(pc_nxt_o == 32'h18 && psr_o[5], "R7 irq under fiq mask", pc_nxt_o, 32'h18);
    rtn(1'b0, 32'h500);
    // R3 software interrupt leaves FIQ mask clear
    wr(mk(4'h3, 1'b0, 1'b0, MS));
    exc(7'b100_0000, 32'h600);
    chk(psr_o[6:5] == 2'b10, "R3 swi fiq mask unchanged", 32'(psr_o[6:5]), 32'h2);
    rtn(1'b0, 32'h600);

    // R12 undefined bank untouched by later entries
    wr(mk(4'h3, 1'b0, 1'b0, MD));
    chk(lr_o == 32'h104, "R12 undefined lr kept", lr_o, 32'h104);
    wr(mk(4'h3, 1'b0, 1'b0, MS));

    // R11 user mode writes only flags
    wr(mk(4'h5, 1'b0, 1'b0, MU));
    wr(mk(4'hF, 1'b1, 1'b1, MS));
    chk(psr_o == mk(4'hF, 1'b0, 1'b0, MU), "R11 user flags only", 32'(psr_o),
        32'(mk(4'hF, 1'b0, 1'b0, MU)));
    // R9 return in user mode
    rtn(1'b1, 32'h777);
    chk(err_o && !redir_o && psr_o == mk(4'hF, 1'b0, 1'b0, MU), "R9 user return",
        32'(err_o), 32'h1);
    // R8 swi from user and back
    exc(7'b100_0000, 32'h800);
    rtn(1'b1, 32'h800);
    chk(psr_o[4:0] == MU, "R8 back to user", 32'(psr_o[4:0]), 32'(MU));
    // R10 reset request from user: flags kept, svc lr unchanged
    exc(7'b000_0001, 32'h900);
    chk(psr_o == mk(4'hF, 1'b1, 1'b1, MS) && pc_nxt_o == 32'h0, "R10 reset entry",
        32'(psr_o), 32'(mk(4'hF, 1'b1, 1'b1, MS)));
    chk(lr_o == 32'h804, "R10 lr untouched", lr_o, 32'h804);
    // R11 exception beats return
    step(7'b010_0000, 1'b1, 1'b0, 32'hABC, 32'hA00, 1'b1, 11'h0);
    chk(pc_nxt_o == 32'h04, "R11 exception over return", pc_nxt_o, 32'h04);
    // R9 return in system mode
    wr(mk(4'h1, 1'b0, 1'b0, MY));
    rtn(1'b0, 32'h55);
    chk(err_o, "R9 system return", 32'(err_o), 32'h1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] rq;
      logic rd, rl, we;
      for (int k = 1; k < 7; k++) rq[k] = (($urandom % 9) == 0);
      rq[0] = (($urandom % 80) == 0);
      rd = (($urandom % 6) == 0);
      rl = (($urandom % 10) == 0);
      we = (($urandom % 4) == 0);
      step(rq, rd, rl, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, we,
           mk(4'($urandom), 1'($urandom), 1'($urandom), modes[$urandom % 7]));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule